// File: doc/BRIEF.md
# Binary Add/Subtract Unit with Status Flags

This block performs add-with-carry and subtract-with-borrow on two operands in pure binary form, and works out the negative, zero, carry and overflow flags of a classic 8-bit processor status byte. It takes the accumulator value, an operand, the current status byte and an operation select. One clock later it presents the result and an updated status byte from registers.

The incoming carry feeds both operations. Subtraction adds the one's complement of the operand plus the carry, so a carry of 1 means "no borrow pending". The carry out of that sum again reads as "no borrow occurred". Overflow follows the signs of the two effective addends and the result. No decimal correction is ever applied, and the decimal bit of the status byte only passes through unchanged.

The unit is meant to sit in the execute stage of a small processor core. The decoder feeds it, and the accumulator and status registers take back its outputs.

Top module: `bin_arith_unit`

## Requirements
- R1: With `op` = 0 (add), `res_out` becomes the low DATA_W bits of acc_in + operand + stat_in[0].
- R2: With `op` = 1 (subtract), `res_out` becomes the low DATA_W bits of acc_in + ~operand + stat_in[0], which equals acc_in - operand - (1 - stat_in[0]).
- R3: The carry, stat_out bit 0, is bit DATA_W of the (DATA_W+1)-bit sum for both operations. When subtracting, it is 1 exactly when acc_in >= operand + (1 - stat_in[0]).
- R4: The overflow flag, stat_out bit 6, is set when both effective addends (acc_in, and operand or ~operand) share a sign bit and the result's sign bit differs. It is cleared whenever the effective addends differ in sign.
- R5: The negative flag, stat_out bit 7, equals the result's top bit. The zero flag, stat_out bit 1, is set exactly when the result is all zeros.
- R6: stat_out bit 5 is always 1, and stat_out bits 4, 3 and 2 are copies of the same bits of stat_in.
- R7: The decimal bit, stat_in bit 3, has no effect on the result or on any flag.
- R8: Outputs are registered. `out_valid` rises one cycle after a cycle with `in_valid` high. In a cycle after `in_valid` was low, `out_valid` is 0 and `res_out` and `stat_out` hold their values.
- R9: A synchronous active-high reset clears `out_valid` and `res_out` and sets `stat_out` to 0x20.
- R10: At DATA_W = 8, adding 0x7F to 0x7F with stat_in = 0x25 gives 0xFF and stat_out = 0xE4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op | input | 1 | 0 = add with carry, 1 = subtract with borrow |
| acc_in | input | DATA_W | Accumulator operand |
| operand | input | DATA_W | Second operand |
| stat_in | input | 8 | Current status byte (bit 0 carry, bit 3 decimal) |
| out_valid | output | 1 | Result registers loaded last cycle |
| res_out | output | DATA_W | Registered result |
| stat_out | output | 8 | Registered updated status byte |

## Verification
The bench builds one instance at DATA_W = 4. There it sweeps every operation, accumulator, operand, carry and decimal-bit value, so every carry and overflow boundary of a narrow word is reached. A second instance at DATA_W = 8 with the ripple carry chain runs every accumulator value against the operands sitting on the sign and magnitude edges (0x00, 0x01, 0x7E, 0x7F, 0x80, 0x81, 0xFE, 0xFF), plus the stated 0x7F + 0x7F case. Expected values come from signed and unsigned integer sums, and overflow is judged by whether the signed sum leaves the word's range.

// File: rtl/bin_arith_pkg.sv
package bin_arith_pkg;
  localparam int ST_W   = 8;
  localparam int ST_NEG = 7;
  localparam int ST_OVF = 6;
  localparam int ST_ONE = 5;
  localparam int ST_ZER = 1;
  localparam int ST_CRY = 0;
  localparam logic [ST_W-1:0] ST_RESET = 8'h20;

  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } arith_op_e;

  typedef struct packed {
    logic neg;
    logic ovf;
    logic zer;
    logic cry;
  } flag_set_t;
endpackage

// File: rtl/bin_addsub_core.sv
module bin_addsub_core #(
  parameter int DATA_W = 8,
  parameter bit RIPPLE = 1'b0
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] m,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] m_eff;

  assign m_eff = sub ? ~m : m;

  generate
    if (RIPPLE) begin : g_ripple
      logic [DATA_W:0] cy;
      assign cy[0] = cin;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign sum[i]  = a[i] ^ m_eff[i] ^ cy[i];
        assign cy[i+1] = (a[i] & m_eff[i]) | (cy[i] & (a[i] ^ m_eff[i]));
      end
      assign cout = cy[DATA_W];
    end else begin : g_behav
      logic [DATA_W:0] total;
      assign total = {1'b0, a} + {1'b0, m_eff} + {{DATA_W{1'b0}}, cin};
      assign sum   = total[MSB:0];
      assign cout  = total[DATA_W];
    end
  endgenerate

  // Same-sign addends with a result of the other sign.
  assign ovf = ~(a[MSB] ^ m_eff[MSB]) & (sum[MSB] ^ a[MSB]);
endmodule

// File: rtl/bin_flag_gen.sv
module bin_flag_gen #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] res,
  output logic              neg,
  output logic              zer
);
  assign neg = res[DATA_W-1];
  assign zer = (res == '0);
endmodule

// File: rtl/bin_status_merge.sv
module bin_status_merge
  import bin_arith_pkg::*;
(
  input  logic [ST_W-1:0] st_old,
  input  flag_set_t       flags,
  output logic [ST_W-1:0] st_new
);
  always_comb begin
    st_new         = st_old;
    st_new[ST_NEG] = flags.neg;
    st_new[ST_OVF] = flags.ovf;
    st_new[ST_ONE] = 1'b1;
    st_new[ST_ZER] = flags.zer;
    st_new[ST_CRY] = flags.cry;
  end
endmodule

// File: rtl/bin_arith_unit.sv
module bin_arith_unit
  import bin_arith_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter bit RIPPLE = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              op,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] operand,
  input  logic [7:0]        stat_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_out,
  output logic [7:0]        stat_out
);
  logic [DATA_W-1:0] sum_c;
  logic              cout_c;
  logic              ovf_c;
  logic              neg_c;
  logic              zer_c;
  flag_set_t         flags_c;
  logic [ST_W-1:0]   st_c;

  bin_addsub_core #(
    .DATA_W(DATA_W),
    .RIPPLE(RIPPLE)
  ) u_core (
    .a   (acc_in),
    .m   (operand),
    .cin (stat_in[ST_CRY]),
    .sub (op == OP_SUB),
    .sum (sum_c),
    .cout(cout_c),
    .ovf (ovf_c)
  );

  bin_flag_gen #(
    .DATA_W(DATA_W)
  ) u_flags (
    .res(sum_c),
    .neg(neg_c),
    .zer(zer_c)
  );

  assign flags_c = '{neg: neg_c, ovf: ovf_c, zer: zer_c, cry: cout_c};

  bin_status_merge u_merge (
    .st_old(stat_in),
    .flags (flags_c),
    .st_new(st_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_out   <= '0;
      stat_out  <= ST_RESET;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_out  <= sum_c;
        stat_out <= st_c;
      end
    end
  end
endmodule

// File: rtl/bin_arith_unit_chk.sv
module bin_arith_unit_chk
  import bin_arith_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              op,
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] operand,
  input logic [7:0]        stat_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] res_out,
  input logic [7:0]        stat_out
);
  localparam int MSB = DATA_W - 1;
  localparam int W1  = DATA_W + 1;

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADD) |=>
      res_out == DATA_W'($past(acc_in) + $past(operand) + DATA_W'($past(stat_in[ST_CRY])))); // R1

  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SUB) |=>
      res_out == DATA_W'($past(acc_in) - $past(operand) - DATA_W'(!$past(stat_in[ST_CRY])))); // R2

  AST_SUB_BORROW: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SUB) |=>
      stat_out[ST_CRY] == ({1'b0, $past(acc_in)} >=
                           ({1'b0, $past(operand)} + W1'(!$past(stat_in[ST_CRY]))))); // R3

  AST_NO_OVF_ADD_MIXED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_ADD && acc_in[MSB] != operand[MSB]) |=> !stat_out[ST_OVF]); // R4

  AST_NO_OVF_SUB_LIKE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == OP_SUB && acc_in[MSB] == operand[MSB]) |=> !stat_out[ST_OVF]); // R4

  AST_NZ_FLAGS: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (stat_out[ST_NEG] == res_out[MSB] &&
                   stat_out[ST_ZER] == (res_out == '0))); // R5

  AST_PASS_BITS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (stat_out[ST_ONE] && stat_out[4:2] == $past(stat_in[4:2]))); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_out) && $stable(stat_out))); // R8

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R8
endmodule

bind bin_arith_unit bin_arith_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/bin_arith_unit_test.sv
module bin_arith_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int WW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;

  logic          n_in_valid = 1'b0, n_op = 1'b0;
  logic [NW-1:0] n_acc = '0, n_opd = '0;
  logic [7:0]    n_st = '0;
  logic          n_out_valid;
  logic [NW-1:0] n_res;
  logic [7:0]    n_st_out;

  logic          w_in_valid = 1'b0, w_op = 1'b0;
  logic [WW-1:0] w_acc = '0, w_opd = '0;
  logic [7:0]    w_st = '0;
  logic          w_out_valid;
  logic [WW-1:0] w_res;
  logic [7:0]    w_st_out;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_arith_unit #(.DATA_W(NW), .RIPPLE(1'b0)) uut (
    .clk(clk), .rst(rst), .in_valid(n_in_valid), .op(n_op),
    .acc_in(n_acc), .operand(n_opd), .stat_in(n_st),
    .out_valid(n_out_valid), .res_out(n_res), .stat_out(n_st_out)
  );

  bin_arith_unit #(.DATA_W(WW), .RIPPLE(1'b1)) uut_w8 (
    .clk(clk), .rst(rst), .in_valid(w_in_valid), .op(w_op),
    .acc_in(w_acc), .operand(w_opd), .stat_in(w_st),
    .out_valid(w_out_valid), .res_out(w_res), .stat_out(w_st_out)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Reference from integer arithmetic: unsigned for result/carry, signed for V.
  task automatic check_vec(input int w, input int op, input int a, input int m,
                           input int st, input int got_v, input int got_r,
                           input int got_s);
    int mask, c, uns, res, cy, sa, sm, ssum, ovf, n, z, exp_s;
    string dtag;
    mask = (1 << w) - 1;
    c    = st & 1;
    if (op == 0) uns = a + m + c;
    else         uns = a + (mask - m) + c;
    res = uns & mask;
    cy  = (uns >> w) & 1;
    sa  = (a >= (1 << (w-1))) ? a - (1 << w) : a;
    sm  = (m >= (1 << (w-1))) ? m - (1 << w) : m;
    ssum = (op == 0) ? sa + sm + c : sa - sm - (1 - c);
    ovf = (ssum > (1 << (w-1)) - 1 || ssum < -(1 << (w-1))) ? 1 : 0;
    n   = (res >> (w-1)) & 1;
    z   = (res == 0) ? 1 : 0;
    exp_s = (n << 7) | (ovf << 6) | 32 | (st & 8'h1C) | (z << 1) | cy;
    dtag = ((st & 8) != 0) ? " R7" : "";
    chk({"R8 valid", dtag}, got_v, 1);
    chk({(op == 0) ? "R1 add result" : "R2 sub result", dtag}, got_r, res);
    chk({"R3 carry", dtag}, got_s & 1, cy);
    chk({"R4 overflow", dtag}, (got_s >> 6) & 1, ovf);
    chk({"R5 N/Z", dtag}, got_s & 8'h82, (n << 7) | (z << 1));
    chk({"R6 fixed/pass bits", dtag}, got_s & 8'h3C, 32 | (st & 8'h1C));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int prev_r, prev_s;
    int picks[8] = '{8'h00, 8'h01, 8'h7E, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF};
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset valid", {31'd0, n_out_valid}, 0);
    chk("R9 reset result", int'(n_res), 0);
    chk("R9 reset status", int'(n_st_out), 8'h20);
    chk("R9 reset status w8", int'(w_st_out), 8'h20);
    rst = 1'b0;

    // Exhaustive narrow sweep; stat_in patterns vary decimal and pass bits.
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 16; a++)
        for (int m = 0; m < 16; m++)
          for (int c = 0; c < 2; c++)
            for (int d = 0; d < 2; d++) begin
              int st;
              st = c | (d << 3) | (((a ^ m) & 1) << 2) | ((m & 2) << 3) | 8'hC2;
              @(negedge clk);
              n_in_valid = 1'b1;
              n_op  = op[0];
              n_acc = NW'(a);
              n_opd = NW'(m);
              n_st  = st[7:0];
              @(negedge clk);
              n_in_valid = 1'b0;
              check_vec(NW, op, a, m, st, int'(n_out_valid), int'(n_res), int'(n_st_out));
            end

    // R8: idle cycle holds outputs and drops valid
    prev_r = int'(n_res);
    prev_s = int'(n_st_out);
    n_acc = 4'h5;
    n_opd = 4'h9;
    n_st  = 8'h08;
    @(negedge clk);
    chk("R8 idle valid low", {31'd0, n_out_valid}, 0);
    chk("R8 idle result hold", int'(n_res), prev_r);
    chk("R8 idle status hold", int'(n_st_out), prev_s);

    // Wide instance: every accumulator against edge operands
    for (int op = 0; op < 2; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 8; k++)
          for (int c = 0; c < 2; c++) begin
            int st;
            st = c | ((a & 1) << 3) | 8'h24;
            @(negedge clk);
            w_in_valid = 1'b1;
            w_op  = op[0];
            w_acc = WW'(a);
            w_opd = WW'(picks[k]);
            w_st  = st[7:0];
            @(negedge clk);
            w_in_valid = 1'b0;
            check_vec(WW, op, a, picks[k], st, int'(w_out_valid), int'(w_res), int'(w_st_out));
          end

    // R10: stated example
    @(negedge clk);
    w_in_valid = 1'b1;
    w_op  = 1'b0;
    w_acc = 8'h7F;
    w_opd = 8'h7F;
    w_st  = 8'h25;
    @(negedge clk);
    w_in_valid = 1'b0;
    chk("R10 example result", int'(w_res), 8'hFF);
    chk("R10 example status", int'(w_st_out), 8'hE4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule